// File: doc/BRIEF.md
# Multiplexed asynchronous bus slave bridge

This block is the device end of an asynchronous parallel memory bus driven by a host controller. The host sends no clock. Address and data share one 16-bit bidirectional path. The bus uses active-low strobes for chip select, address latch, read and write, plus two active-low byte-lane enables. The block brings each of the four strobes into its own clock domain through a multi-flop synchroniser. It acts only on synchronised edges: it latches the address, decodes it into a bank of control registers, a bank of status registers or a single 16-bit FIFO window, and then serves the read or write.

The host sizes its bus timing around the synchroniser latency. It holds the address phase for four slave clocks and the data phase for six, and it waits four clocks of turnaround after a cycle. The block drives the shared lines only during a read data phase. It releases them before the host can start the next address phase. The register contents and the FIFO sit outside the block. The block presents a register index, a bank select and write strobes to them, and it takes a read value and the FIFO head from them.

Top module: `muxbus_slave`

## Requirements
- R1: While reset is held, `bus_ad_oe`, `bus_ad_o`, `reg_wr`, `fifo_push` and `fifo_pop` are all zero.
- R2: The block captures the address from `bus_ad_i` on the first synchronised sample that shows the latch strobe low with chip select low. This is the fourth clock edge after both fall.
- R3: The address map is as follows. Even addresses 0x00 to 0x14 select control register `addr/2` (`reg_stat`=0). Even addresses 0x20 to 0x2A select status register `(addr-0x20)/2` (`reg_stat`=1). Address 0x40 selects the FIFO window. Every other address, including every odd one, is undecoded.
- R4: `bus_ad_oe` rises in the fourth cycle after the read strobe falls (the latch strobe having risen earlier) and falls in the fourth cycle after chip select or read strobe rises. It is never high while the latch strobe is low or during a write.
- R5: A read of a register places `reg_rdata` on `bus_ad_o`. The value is taken at the edge where the synchronised read strobe falls, and it is valid from the cycle `bus_ad_oe` rises.
- R6: A control-register write gives one `reg_wr` pulse in the fourth cycle after the write strobe falls. The pulse carries `wr_data` and `wr_be` as sampled at that edge: `wr_be[0]` is the low byte, and it is the inverse of `bus_be_n[0]`. The same holds for `wr_be[1]` and the high byte.
- R7: A write with both byte-lane enables high (no lane selected) produces neither `reg_wr` nor `fifo_push`.
- R8: A read of the FIFO window returns `fifo_rdata` and gives exactly one `fifo_pop` pulse, in the cycle after the data was taken.
- R9: A write of the FIFO window gives exactly one `fifo_push` pulse, with `wr_data`, four cycles after the write strobe falls.
- R10: Reads of undecoded addresses return zero. Writes to undecoded addresses or to the status bank produce no strobe.
- R11: A bus cycle run with chip select high produces no drive and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_lat_n | input | 1 | Address latch strobe, active low |
| bus_oe_n | input | 1 | Read strobe, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_be_n | input | 2 | Byte-lane enables, active low, bit 0 low byte |
| bus_ad_i | input | 16 | Shared address/data lines as seen at the pins |
| bus_ad_o | output | 16 | Read data driven onto the shared lines |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| reg_idx | output | 4 | Decoded register index within its bank |
| reg_stat | output | 1 | 1 selects the status bank, 0 the control bank |
| reg_rdata | input | 16 | Value of the selected register |
| reg_wr | output | 1 | Control register write pulse |
| wr_data | output | 16 | Write data for register or FIFO |
| wr_be | output | 2 | Byte lanes of the write, active high |
| fifo_rdata | input | 16 | Head of the FIFO |
| fifo_pop | output | 1 | FIFO pop pulse |
| fifo_push | output | 1 | FIFO push pulse |

## Verification
Each result is due a fixed number of edges after the raw strobe that causes it. The address is captured at the fourth edge after the latch strobe falls. The read value, the drive enable and every strobe appear in the fourth cycle after the read or write strobe falls. The drive enable falls four cycles after release. The bench runs each host bus cycle as sixteen numbered steps. At each falling edge it first records the outputs for that step and only then applies that step's inputs. It then compares the drive enable against the expected per-step pattern, the read value at the step where the host samples, and the step at which a strobe occurred. A sweep over every byte address for reads and writes covers the map. The byte-lane pattern rotates with the address.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CTRL = 2'd1,
    RGN_STAT = 2'd2,
    RGN_FIFO = 2'd3
  } rgn_e;
endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/muxbus_decode.sv
module muxbus_decode
  import muxbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int IDX_W = 4,
  parameter int NUM_CTRL = 11,
  parameter int NUM_STAT = 6,
  parameter int CTRL_BASE = 0,
  parameter int STAT_BASE = 32,
  parameter int FIFO_ADDR = 64
) (
  input  logic [DW-1:0]    addr,
  output rgn_e             rgn,
  output logic [IDX_W-1:0] idx
);
  localparam logic [DW-1:0] CTRL_SPAN = DW'(2 * NUM_CTRL);
  localparam logic [DW-1:0] STAT_SPAN = DW'(2 * NUM_STAT);

  logic [DW-1:0] off_ctrl;
  logic [DW-1:0] off_stat;

  always_comb begin
    off_ctrl = addr - DW'(CTRL_BASE);
    off_stat = addr - DW'(STAT_BASE);
    rgn = RGN_NONE;
    idx = '0;
    if (addr[0]) begin
      rgn = RGN_NONE;
    end else if (addr == DW'(FIFO_ADDR)) begin
      rgn = RGN_FIFO;
    end else if (off_ctrl < CTRL_SPAN) begin
      rgn = RGN_CTRL;
      idx = off_ctrl[IDX_W:1];
    end else if (off_stat < STAT_SPAN) begin
      rgn = RGN_STAT;
      idx = off_stat[IDX_W:1];
    end
  end
endmodule

// File: rtl/muxbus_rdpath.sv
module muxbus_rdpath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          drive_req,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe
);
  logic [DW-1:0] data_q, data_nxt;
  logic          oe_q, oe_nxt;

  always_comb begin
    data_nxt = load_en ? load_val : data_q;
    oe_nxt   = drive_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_nxt;
      oe_q   <= oe_nxt;
    end
  end

  assign ad_o  = data_q;
  assign ad_oe = oe_q;
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import muxbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 3,
  parameter int NUM_CTRL = 11,
  parameter int NUM_STAT = 6,
  parameter int CTRL_BASE = 0,
  parameter int STAT_BASE = 32,
  parameter int FIFO_ADDR = 64,
  localparam int MAX_REGS = (NUM_CTRL > NUM_STAT) ? NUM_CTRL : NUM_STAT,
  localparam int IDX_W = $clog2(MAX_REGS),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_lat_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [LANES-1:0]  bus_be_n,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_stat,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_wr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              fifo_pop,
  output logic              fifo_push
);
  localparam int NSTROBE = 4;

  // reset: asserted asynchronously, released on the clock
  logic rst_l_n;
  muxbus_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_l_n)
  );

  // strobe synchroniser, idle value is all ones
  logic [NSTROBE-1:0] strb_raw, strb_s;
  assign strb_raw = {bus_ce_n, bus_lat_n, bus_oe_n, bus_we_n};
  muxbus_sync #(.WIDTH(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL({NSTROBE{1'b1}})) u_strb_sync (
    .clk(clk), .rst_n(rst_l_n), .d(strb_raw), .q(strb_s)
  );

  logic ce_s, lat_s, oe_s, we_s;
  assign {ce_s, lat_s, oe_s, we_s} = strb_s;

  // state
  logic              lat_d, oe_d, we_d;
  logic [DATA_W-1:0] addr_q, addr_nxt;
  logic              addr_en;
  logic [DATA_W-1:0] wdat_q, wdat_nxt;
  logic [LANES-1:0]  wbe_q, wbe_nxt;
  logic              wcap_en;
  logic              regwr_q, regwr_nxt;
  logic              push_q, push_nxt;
  logic              pop_q, pop_nxt;

  // decode of the held address
  rgn_e             rgn;
  logic [IDX_W-1:0] idx;
  muxbus_decode #(
    .DW(DATA_W), .IDX_W(IDX_W), .NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT),
    .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE), .FIFO_ADDR(FIFO_ADDR)
  ) u_decode (
    .addr(addr_q), .rgn(rgn), .idx(idx)
  );

  // edge detection on synchronised strobes
  logic lat_fall, oe_fall, we_fall, lane_any, drive_req;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    lat_fall  = !ce_s && !lat_s && lat_d;
    oe_fall   = !ce_s && !oe_s && oe_d && lat_s;
    we_fall   = !ce_s && !we_s && we_d && lat_s;
    lane_any  = !(&bus_be_n);
    drive_req = !ce_s && !oe_s && lat_s;

    addr_en   = lat_fall;
    addr_nxt  = addr_en ? bus_ad_i : addr_q;

    wcap_en   = we_fall;
    wdat_nxt  = wcap_en ? bus_ad_i : wdat_q;
    wbe_nxt   = wcap_en ? ~bus_be_n : wbe_q;

    regwr_nxt = we_fall && lane_any && (rgn == RGN_CTRL);
    push_nxt  = we_fall && lane_any && (rgn == RGN_FIFO);
    pop_nxt   = oe_fall && (rgn == RGN_FIFO);

    unique case (rgn)
      RGN_CTRL, RGN_STAT: rd_val = reg_rdata;
      RGN_FIFO:           rd_val = fifo_rdata;
      default:            rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l_n) begin
    if (!rst_l_n) begin
      lat_d   <= 1'b1;
      oe_d    <= 1'b1;
      we_d    <= 1'b1;
      addr_q  <= '0;
      wdat_q  <= '0;
      wbe_q   <= '0;
      regwr_q <= 1'b0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
    end else begin
      lat_d   <= lat_s;
      oe_d    <= oe_s;
      we_d    <= we_s;
      addr_q  <= addr_nxt;
      wdat_q  <= wdat_nxt;
      wbe_q   <= wbe_nxt;
      regwr_q <= regwr_nxt;
      push_q  <= push_nxt;
      pop_q   <= pop_nxt;
    end
  end

  // read data register and pin drive enable
  muxbus_rdpath #(.DW(DATA_W)) u_rdpath (
    .clk(clk), .rst_n(rst_l_n), .load_en(oe_fall), .load_val(rd_val),
    .drive_req(drive_req), .ad_o(bus_ad_o), .ad_oe(bus_ad_oe)
  );

  assign reg_idx   = idx;
  assign reg_stat  = (rgn == RGN_STAT);
  assign reg_wr    = regwr_q;
  assign wr_data   = wdat_q;
  assign wr_be     = wbe_q;
  assign fifo_push = push_q;
  assign fifo_pop  = pop_q;
endmodule

module muxbus_slave_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_lat_n,
  input logic             bus_ad_oe,
  input logic             reg_wr,
  input logic [LANES-1:0] wr_be,
  input logic             fifo_push,
  input logic             fifo_pop
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!bus_ad_oe && !reg_wr && !fifo_push && !fifo_pop));

  assert_no_drive_in_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> bus_lat_n);

  assert_lane_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (wr_be != '0));

  assert_single_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  assert_single_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> !fifo_push);

  assert_push_not_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !reg_wr);
endmodule

bind muxbus_slave muxbus_slave_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_lat_n(bus_lat_n), .bus_ad_oe(bus_ad_oe),
  .reg_wr(reg_wr), .wr_be(wr_be), .fifo_push(fifo_push), .fifo_pop(fifo_pop)
);

// File: tb/muxbus_slave_bench.sv
`timescale 1ns/1ps
module muxbus_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_ce_n, bus_lat_n, bus_oe_n, bus_we_n;
  logic [1:0]  bus_be_n;
  logic [15:0] bus_ad_i, bus_ad_o;
  logic        bus_ad_oe;
  logic [3:0]  reg_idx;
  logic        reg_stat;
  logic [15:0] reg_rdata;
  logic        reg_wr;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;
  logic [15:0] fifo_rdata;
  logic        fifo_pop, fifo_push;

  logic        host_en;
  logic [15:0] host_val;
  int          fifo_head;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          wr_cnt = 0, push_cnt = 0, pop_cnt = 0;
  logic [3:0]  last_idx;
  logic [15:0] last_d;
  logic [1:0]  last_be;

  always #2 clk = ~clk;

  // shared lines: host, else slave, else pulled high
  assign bus_ad_i = host_en ? host_val : (bus_ad_oe ? bus_ad_o : 16'hFFFF);
  // register file and FIFO models
  assign reg_rdata  = 16'hC000 | (reg_stat ? 16'h0100 : 16'h0000) | {12'h000, reg_idx};
  assign fifo_rdata = 16'hF000 + 16'(fifo_head);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) fifo_head <= 0;
    else if (fifo_pop) fifo_head <= fifo_head + 1;

  always @(negedge clk) begin
    if (reg_wr) begin
      wr_cnt++; last_idx = reg_idx; last_d = wr_data; last_be = wr_be;
    end
    if (fifo_push) begin
      push_cnt++; last_d = wr_data; last_be = wr_be;
    end
    if (fifo_pop) pop_cnt++;
  end

  muxbus_slave u_muxbus_slave (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_lat_n(bus_lat_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_be_n(bus_be_n),
    .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
    .reg_idx(reg_idx), .reg_stat(reg_stat), .reg_rdata(reg_rdata),
    .reg_wr(reg_wr), .wr_data(wr_data), .wr_be(wr_be),
    .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .fifo_push(fifo_push)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one host bus cycle, 16 steps; outputs observed before inputs change
  task automatic bus_cycle(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                           input logic [1:0] ben, input bit ce_on);
    int w0 = wr_cnt, p0 = push_cnt, q0 = pop_cnt, head0 = fifo_head;
    logic [15:0] hist = '0;
    logic [15:0] rdv = '0;
    int stb_step = -1;
    bit is_ctrl = (a[0] == 1'b0) && (a < 16'h16);
    bit is_stat = (a[0] == 1'b0) && (a >= 16'h20) && (a < 16'h2C);
    bit is_fifo = (a == 16'h40);
    bit lanes   = (ben != 2'b11);
    logic [15:0] exp_rd;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      hist[c] = bus_ad_oe;
      if (c == 10) rdv = bus_ad_o;
      if (reg_wr || fifo_push || fifo_pop) stb_step = c;
      bus_ce_n  = !(ce_on && c <= 10);
      bus_lat_n = !(c <= 3);
      bus_oe_n  = !(!wr && c >= 5 && c <= 10);
      bus_we_n  = !(wr && c >= 5 && c <= 10);
      bus_be_n  = ben;
      host_en   = (c <= 4) || (wr && c >= 5 && c <= 10);
      host_val  = (c <= 4) ? a : wd;
    end
    if (!ce_on) begin
      chk(hist == 16'h0000, "R11 no drive without chip select", hist, 0);
      chk(wr_cnt == w0 && push_cnt == p0 && pop_cnt == q0, "R11 no strobe without chip select",
          wr_cnt + push_cnt + pop_cnt, w0 + p0 + q0);
    end else if (!wr) begin
      chk(hist == 16'h7E00, "R4 drive window steps 9..14", hist, 16'h7E00);
      if (is_ctrl)      exp_rd = 16'hC000 | 16'(a >> 1);
      else if (is_stat) exp_rd = 16'hC100 | 16'((a - 16'h20) >> 1);
      else if (is_fifo) exp_rd = 16'hF000 + 16'(head0);
      else              exp_rd = 16'h0000;
      if (is_ctrl || is_stat) chk(rdv == exp_rd, "R5 R3 R2 register read data", rdv, exp_rd);
      else if (is_fifo)       chk(rdv == exp_rd, "R8 fifo read data", rdv, exp_rd);
      else                    chk(rdv == exp_rd, "R10 undecoded read zero", rdv, exp_rd);
      chk(pop_cnt - q0 == (is_fifo ? 1 : 0), "R8 pop count", pop_cnt - q0, is_fifo ? 1 : 0);
      if (is_fifo) chk(stb_step == 9, "R8 pop step", stb_step, 9);
    end else begin
      chk(hist == 16'h0000, "R4 no drive during write", hist, 0);
      chk(wr_cnt - w0 == ((is_ctrl && lanes) ? 1 : 0), "R6 R7 R10 reg write count",
          wr_cnt - w0, (is_ctrl && lanes) ? 1 : 0);
      chk(push_cnt - p0 == ((is_fifo && lanes) ? 1 : 0), "R9 R7 push count",
          push_cnt - p0, (is_fifo && lanes) ? 1 : 0);
      if ((is_ctrl || is_fifo) && lanes) begin
        chk(stb_step == 9, "R6 R9 strobe step", stb_step, 9);
        chk(last_d == wd, "R6 R9 write data", last_d, wd);
        chk(last_be == ~ben, "R6 byte lanes", last_be, ~ben);
      end
      if (is_ctrl && lanes) chk(last_idx == 4'(a >> 1), "R3 R2 write index", last_idx, 4'(a >> 1));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    bus_ce_n = 1'b1; bus_lat_n = 1'b1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
    bus_be_n = 2'b11; host_en = 1'b0; host_val = '0;
    repeat (3) @(negedge clk);
    chk(!bus_ad_oe && bus_ad_o == 16'h0 && !reg_wr && !fifo_push && !fifo_pop,
        "R1 reset state", {bus_ad_oe, reg_wr, fifo_push, fifo_pop, bus_ad_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_ad_oe && !reg_wr, "R1 idle after reset", {bus_ad_oe, reg_wr}, 0);

    for (int a = 0; a < 128; a++)
      bus_cycle(1'b0, 16'(a), 16'h0, 2'b00, 1'b1);
    for (int a = 0; a < 128; a++)
      bus_cycle(1'b1, 16'(a), (16'(a) * 16'h0101) ^ 16'h5A3C, 2'((a >> 1) & 3), 1'b1);

    bus_cycle(1'b0, 16'h0040, 16'h0, 2'b00, 1'b1);
    bus_cycle(1'b0, 16'h0040, 16'h0, 2'b00, 1'b1);
    bus_cycle(1'b1, 16'h0040, 16'h1234, 2'b11, 1'b1);
    bus_cycle(1'b1, 16'h0040, 16'hBEEF, 2'b10, 1'b1);
    bus_cycle(1'b0, 16'h0002, 16'h0, 2'b00, 1'b0);
    bus_cycle(1'b1, 16'h0004, 16'h7777, 2'b00, 1'b0);
    bus_cycle(1'b0, 16'h0040, 16'h0, 2'b00, 1'b0);
    bus_cycle(1'b0, 16'h0014, 16'h0, 2'b00, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule